// File: doc/BRIEF.md
# Asynchronous slave FIFO read port

This block lets an outside master with no clock of its own read words out of a bank of small internal FIFOs. The master drives a FIFO-select code, a chip select, an output enable and a read strobe. The block brings all four controls into its own clock domain through a two-stage synchroniser. It presents data on a bus that is modelled as a data vector plus a drive-enable output, which stands for the tri-state buffer.

Output enable controls only whether the bus is driven. A chip-select-qualified read strobe loads the head word of the selected FIFO into the bus register. When the strobe is released, the block pops that FIFO. Between strobes the bus keeps the last word that was read. If a strobe arrives while the selected FIFO is empty, no pointer moves and a sticky per-FIFO underflow bit is set. A simple clocked write side fills the FIFOs for loading and test.

Top module: `afifo_rd_port`

## Requirements
- R1: While and right after reset, `bus_oe_o` is 0, `bus_o` is 0, every `empty_no` bit is 0 and every `underflow_o` bit is 0.
- R2: `bus_oe_o` follows `oe_i` through the synchroniser. When `oe_i` is low, `bus_oe_o` is 0, which means the bus is at high impedance.
- R3: Raising `oe_i` with no read strobe drives the word from the previous read, or 0 if there has been no read since reset. It does not advance any FIFO.
- R4: A read is recognised only while `cs_i` and `rd_i` are both 1. A strobe with `cs_i` low changes neither `bus_o` nor any pointer. `cs_i` may rise in the same cycle as `rd_i`.
- R5: When a read is recognised, `bus_o` takes the head word of the FIFO selected by `sel_i`, within 3 internal clocks of the strobe rising.
- R6: The selected FIFO is popped once, when the strobe falls. Successive strobes return words in write order (N, N+1, N+2, ...).
- R7: When `oe_i` is tied to `rd_i`, each pulse drives the bus during the pulse and performs exactly one read.
- R8: A strobe on an empty FIFO leaves its pointer and `bus_o` unchanged and sets bit `sel_i` of `underflow_o`. That bit stays set until reset.
- R9: `empty_no[i]` is active-low: it is 0 when FIFO i holds no word. It is a register that updates one clock after the pointer update.
- R10: Each FIFO, selected by its 2-bit code 0..3, has its own pointers, so reading one FIFO does not disturb another.
- R11: A write (`wr_en_i`) to a FIFO that already holds DEPTH words is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Load-side write strobe, one word per clock |
| wr_sel_i | input | 2 | FIFO chosen for the write |
| wr_data_i | input | 16 | Write word |
| sel_i | input | 2 | Asynchronous FIFO-select code from the master |
| cs_i | input | 1 | Asynchronous chip select, active high |
| oe_i | input | 1 | Asynchronous output enable, active high |
| rd_i | input | 1 | Asynchronous read strobe, active high |
| bus_o | output | 16 | Bus data value |
| bus_oe_o | output | 1 | Bus drive enable, 0 means high impedance |
| empty_no | output | 4 | Per-FIFO empty flag, active low |
| underflow_o | output | 4 | Per-FIFO sticky underflow |

## Verification
The assertions check four things on every cycle. At most one FIFO is popped at a time. A pop only hits a FIFO whose registered flag shows data. Underflow bits never clear. The bus value changes only in the cycle after a recognised read loads it. The bench scenarios are needed for the rest: that the data is correct and in order across a burst, that the chip-select qualification works, that output enable alone replays the old word, that a full FIFO drops an extra write, and that an empty-FIFO strobe leaves the last word in place. These depend on the stimulus history, so only the scenarios can show them.

// File: rtl/afifo_rd_pkg.sv
package afifo_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_MISS = 2'd2
  } rd_state_e;
endpackage

// File: rtl/afifo_ctrl_sync.sv
module afifo_ctrl_sync #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] sync_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= raw_i[b];
        s2_q <= s1_q;
      end
    end
    assign sync_o[b] = s2_q;
  end
endmodule

// File: rtl/afifo_bank.sv
module afifo_bank #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              avail_o,
  output logic              empty_no
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wptr_q, rptr_q;
  logic [AW:0]       cnt_q;
  logic              full, do_wr, do_pop;

  assign full    = (cnt_q == (AW+1)'(DEPTH));
  assign avail_o = (cnt_q != '0);
  assign do_wr   = wr_i && !full;
  assign do_pop  = pop_i && avail_o;
  assign head_o  = mem_q[rptr_q];

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q   <= '0;
      rptr_q   <= '0;
      cnt_q    <= '0;
      empty_no <= 1'b0;
    end else begin
      if (do_wr)  wptr_q <= wptr_q + 1'b1;
      if (do_pop) rptr_q <= rptr_q + 1'b1;
      case ({do_wr, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      // flag lags the pointer/count update by one clock
      empty_no <= avail_o;
    end
  end
endmodule

// File: rtl/afifo_rd_seq.sv
module afifo_rd_seq
  import afifo_rd_pkg::*;
#(
  parameter int N_FIFO = 4,
  parameter int DATA_W = 16,
  parameter int SEL_W  = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [SEL_W-1:0]               sel_i,
  input  logic                           cs_i,
  input  logic                           rd_i,
  input  logic [N_FIFO-1:0][DATA_W-1:0]  head_i,
  input  logic [N_FIFO-1:0]              avail_i,
  output logic [DATA_W-1:0]              data_o,
  output logic                           load_o,
  output logic [N_FIFO-1:0]              pop_o,
  output logic [N_FIFO-1:0]              underflow_o
);
  rd_state_e        st_q, st_d;
  logic [SEL_W-1:0] sel_q;
  logic             rd_act, hit, miss;

  assign rd_act = rd_i && cs_i;
  assign hit    = (st_q == ST_IDLE) && rd_act && avail_i[sel_i];
  assign miss   = (st_q == ST_IDLE) && rd_act && !avail_i[sel_i];
  assign load_o = hit;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (hit) st_d = ST_READ; else if (miss) st_d = ST_MISS;
      ST_READ: if (!rd_act) st_d = ST_IDLE;
      ST_MISS: if (!rd_act) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  for (genvar f = 0; f < N_FIFO; f++) begin : g_pop
    assign pop_o[f] = (st_q == ST_READ) && !rd_act && (sel_q == SEL_W'(f));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      sel_q       <= '0;
      data_o      <= '0;
      underflow_o <= '0;
    end else begin
      st_q <= st_d;
      if (hit) begin
        sel_q  <= sel_i;
        data_o <= head_i[sel_i];
      end
      if (miss) underflow_o[sel_i] <= 1'b1;
    end
  end
endmodule

// File: rtl/afifo_rd_port.sv
module afifo_rd_port #(
  parameter int N_FIFO = 4,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int SEL_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              cs_i,
  input  logic              oe_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o,
  output logic [N_FIFO-1:0] empty_no,
  output logic [N_FIFO-1:0] underflow_o
);
  localparam int CW = SEL_W + 3;

  logic [CW-1:0]                  ctl_s;
  logic [SEL_W-1:0]               sel_s;
  logic                           cs_s, oe_s, rd_s, load;
  logic [N_FIFO-1:0][DATA_W-1:0]  head;
  logic [N_FIFO-1:0]              avail, pop_vec;

  afifo_ctrl_sync #(.W(CW)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i ({sel_i, cs_i, oe_i, rd_i}),
    .sync_o(ctl_s)
  );
  assign {sel_s, cs_s, oe_s, rd_s} = ctl_s;

  for (genvar f = 0; f < N_FIFO; f++) begin : g_fifo
    afifo_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_en_i && (wr_sel_i == SEL_W'(f))),
      .wdata_i (wr_data_i),
      .pop_i   (pop_vec[f]),
      .head_o  (head[f]),
      .avail_o (avail[f]),
      .empty_no(empty_no[f])
    );
  end

  afifo_rd_seq #(.N_FIFO(N_FIFO), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel_s),
    .cs_i       (cs_s),
    .rd_i       (rd_s),
    .head_i     (head),
    .avail_i    (avail),
    .data_o     (bus_o),
    .load_o     (load),
    .pop_o      (pop_vec),
    .underflow_o(underflow_o)
  );

  assign bus_oe_o = oe_s;
endmodule

// File: rtl/afifo_rd_port_chk.sv
module afifo_rd_port_chk #(
  parameter int N_FIFO = 4,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] bus_o,
  input logic              load_i,
  input logic [N_FIFO-1:0] pop_i,
  input logic [N_FIFO-1:0] empty_ni,
  input logic [N_FIFO-1:0] underflow_i
);
  // R6
  single_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pop_i));

  // R9
  pop_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i != '0) |-> ((pop_i & ~empty_ni) == '0));

  // R8
  underflow_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underflow_i != '0) |=> ((underflow_i & $past(underflow_i)) == $past(underflow_i)));

  // R3
  bus_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(bus_o));
endmodule

bind afifo_rd_port afifo_rd_port_chk #(.N_FIFO(N_FIFO), .DATA_W(DATA_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_o      (bus_o),
  .load_i     (load),
  .pop_i      (pop_vec),
  .empty_ni   (empty_no),
  .underflow_i(underflow_o)
);

// File: tb/afifo_rd_port_tb_top.sv
module afifo_rd_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int NF = 4;
  localparam int DEPTH = 16;
  localparam int NVEC = 14;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = '0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0]    sel = '0;
  logic          cs = 1'b0, oe = 1'b0, rd = 1'b0;
  logic [DW-1:0] bus;
  logic          bus_oe;
  logic [NF-1:0] empty_n, uflow;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  afifo_rd_port dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .sel_i(sel), .cs_i(cs), .oe_i(oe), .rd_i(rd),
    .bus_o(bus), .bus_oe_o(bus_oe), .empty_no(empty_n), .underflow_o(uflow)
  );

  // {sel[23:22], cs[21], oe[20], rd[19], exp_oe[18], pad[17:16], exp_data[15:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    {2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b0, 16'h0000}, // R3 oe only, no prior read
    {2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b0, 16'hA000}, // R5
    {2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b0, 16'hA000}, // R6 hold after release
    {2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b0, 16'hA001}, // R6 next word
    {2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b0, 16'hA001},
    {2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 2'b0, 16'hA001}, // R4 strobe without cs
    {2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 2'b0, 16'hA001},
    {2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b0, 16'hB000}, // R10 cs rises with strobe
    {2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 2'b0, 16'hB000},
    {2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b0, 16'hA002}, // R4 no advance earlier
    {2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b0, 16'hA002},
    {2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b0, 16'hA002}, // R2 bus released
    {2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b0, 16'hA003},
    {2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b0, 16'hA003}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic apply(input logic [1:0] s, input logic c, input logic o, input logic r);
    @(negedge clk);
    sel = s; cs = c; oe = o; rd = r;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(bus_oe == 1'b0, "R1 bus_oe", 32'(bus_oe), 0);
    chk(bus == '0, "R1 bus", 32'(bus), 0);
    chk(empty_n == '0, "R1 empty_no", 32'(empty_n), 0);
    chk(uflow == '0, "R1 underflow", 32'(uflow), 0);
    rst_ni = 1'b1;

    for (int i = 0; i < 4; i++) wr(2'd0, 16'hA000 + DW'(i));
    wr(2'd1, 16'hB000);
    for (int i = 0; i <= DEPTH; i++) wr(2'd2, 16'hC000 + DW'(i)); // R11 last is extra
    repeat (2) @(negedge clk);
    chk(empty_n == 4'b0111, "R9 flags after load", 32'(empty_n), 32'h7);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][23:22], VEC[i][21], VEC[i][20], VEC[i][19]);
      chk(bus_oe == VEC[i][18], $sformatf("R2 vec%0d bus_oe", i), 32'(bus_oe), 32'(VEC[i][18]));
      chk(bus == VEC[i][15:0], $sformatf("R5 R6 vec%0d bus", i), 32'(bus), 32'(VEC[i][15:0]));
    end

    // R9 FIFO0 and FIFO1 drained
    chk(empty_n == 4'b0100, "R9 flags after drain", 32'(empty_n), 32'h4);
    chk(uflow == '0, "R8 no underflow yet", 32'(uflow), 0);

    // R8 strobe on empty FIFO0
    apply(2'd0, 1'b1, 1'b1, 1'b1);
    chk(bus == 16'hA003, "R8 bus kept", 32'(bus), 32'hA003);
    apply(2'd0, 1'b1, 1'b1, 1'b0);
    chk(uflow == 4'b0001, "R8 underflow set", 32'(uflow), 1);
    chk(empty_n == 4'b0100, "R8 no pointer move", 32'(empty_n), 32'h4);

    // R7 oe tied to strobe, burst on FIFO2
    for (int i = 0; i < DEPTH; i++) begin
      apply(2'd2, 1'b1, 1'b1, 1'b1);
      chk(bus_oe == 1'b1, "R7 driven in pulse", 32'(bus_oe), 1);
      chk(bus == 16'hC000 + DW'(i), "R7 R6 burst word", 32'(bus), 32'hC000 + i);
      apply(2'd2, 1'b1, 1'b0, 1'b0);
      chk(bus_oe == 1'b0, "R7 released", 32'(bus_oe), 0);
    end
    chk(empty_n == 4'b0000, "R9 FIFO2 empty", 32'(empty_n), 0);

    // R11 extra write dropped: next strobe underflows
    apply(2'd2, 1'b1, 1'b1, 1'b1);
    apply(2'd2, 1'b1, 1'b0, 1'b0);
    chk(bus == 16'hC00F, "R11 bus kept", 32'(bus), 32'hC00F);
    chk(uflow == 4'b0101, "R11 R8 underflow FIFO2 sticky FIFO0", 32'(uflow), 5);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule